// File: doc/BRIEF.md
# Serial SRAM Address Sequencer

This block keeps the internal byte pointer of a serial static RAM front end. When the command decoder has collected the start address of a read or a write, it pulses `load`. The block then captures the address and the transfer mode that applies to the command. After each data byte moves across the serial link, the decoder pulses `advance`, and the block steps the pointer according to the captured mode. Reads and writes use the same sequencing.

Three transfer modes exist. Single-byte mode permits one byte and then reports that no more bytes are allowed. Page mode moves around inside a 32-byte page and does so without limit. Burst mode walks the whole array and wraps from the highest address back to zero. The `more_ok` output tells the shifter whether it may move another byte at the current address. A pulse on `cmd_end` marks the end of the command, for example when chip select rises.

Top module: `addr_seq`

## Requirements
- R1: After reset, `addr` is 0 and `more_ok` is 0.
- R2: A `load` pulse without `cmd_end` makes `addr` equal to `load_addr` and sets `more_ok` to 1 on the next cycle.
- R3: With captured mode page (`mode` = 2'b10), each accepted `advance` adds 1 to `addr[4:0]`, with 31 followed by 0. Bits 14:5 do not change.
- R4: In page mode, `more_ok` stays 1 across any number of advances, so the page can be looped indefinitely.
- R5: With captured mode burst (`mode` = 2'b01), each accepted `advance` adds 1 to the full 15-bit `addr`, and 0x7FFF is followed by 0x0000. `more_ok` stays 1.
- R6: With captured mode single (`mode` = 2'b00), an accepted `advance` leaves `addr` unchanged and clears `more_ok`. Later advances change nothing.
- R7: The reserved code `mode` = 2'b11 behaves exactly like single-byte mode.
- R8: The mode is captured only on `load`. Changes on `mode` between loads have no effect on stepping.
- R9: `advance` is ignored (no change to `addr` or `more_ok`) unless a `load` has occurred since the last reset or `cmd_end`.
- R10: `cmd_end` clears `more_ok` on the next cycle and holds `addr`. It takes priority over a simultaneous `load`.
- R11: When `load` and `advance` occur in the same cycle, the load wins: `addr` becomes `load_addr` and does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_end | input | 1 | End of command (chip select released) |
| load | input | 1 | Capture start address and mode |
| load_addr | input | 15 | Start address of the command |
| mode | input | 2 | Transfer mode: 00 single, 10 page, 01 burst, 11 single |
| advance | input | 1 | One data byte has been transferred |
| addr | output | 15 | Current byte address |
| more_ok | output | 1 | Another byte may be transferred at `addr` |

## Verification
The hardest situations to reach are the wrap points. The page wrap at the top of an upper-bit group must leave bits 14:5 untouched. The burst wrap from 0x7FFF must reach 0x0000. The stimulus reaches both by loading a start address a few bytes below each boundary and then stepping across it, instead of walking from zero. Mode capture is checked by changing the `mode` input after the load and then stepping across a page boundary. At that boundary the page and burst results differ, so the wrong mode shows up at `addr`.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_SINGLE = 2'd0,
    SEQ_PAGE   = 2'd1,
    SEQ_BURST  = 2'd2
  } seq_mode_e;

  // Field code: 2'b10 page, 2'b01 burst, 2'b00 and 2'b11 single
  function automatic seq_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b10:   return SEQ_PAGE;
      2'b01:   return SEQ_BURST;
      default: return SEQ_SINGLE;
    endcase
  endfunction
endpackage

// File: rtl/addr_seq_mode_reg.sv
module addr_seq_mode_reg
  import addr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  logic [1:0] mode_code,
  output seq_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= SEQ_SINGLE;
    else if (capture) mode_q <= decode_mode(mode_code);
  end
endmodule

// File: rtl/addr_seq_step.sv
module addr_seq_step
  import addr_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 5
) (
  input  seq_mode_e         mode_q,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  localparam int HI_W = ADDR_W - PAGE_W;

  function automatic logic [ADDR_W-1:0] burst_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] page_nxt;

  generate
    if (HI_W > 0) begin : g_split
      function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
      endfunction
      assign page_nxt = page_next(cur);
    end else begin : g_whole
      assign page_nxt = burst_next(cur);
    end
  endgenerate

  always_comb begin
    case (mode_q)
      SEQ_PAGE:  nxt = page_nxt;
      SEQ_BURST: nxt = burst_next(cur);
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/addr_seq_ctrl.sv
module addr_seq_ctrl
  import addr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_fire,
  input  logic      adv_fire,
  input  logic      end_fire,
  input  seq_mode_e mode_q,
  output logic      active,
  output logic      more_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      more_ok <= 1'b0;
    end else if (end_fire) begin
      active  <= 1'b0;
      more_ok <= 1'b0;
    end else if (load_fire) begin
      active  <= 1'b1;
      more_ok <= 1'b1;
    end else if (adv_fire && mode_q == SEQ_SINGLE) begin
      more_ok <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_seq.sv
module addr_seq
  import addr_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_end,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [1:0]        mode,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              more_ok
);
  // named events, visible to the bound checker
  logic              end_fire;
  logic              load_fire;
  logic              adv_fire;
  logic              active;
  seq_mode_e         mode_q;
  logic [ADDR_W-1:0] step_addr;

  assign end_fire  = cmd_end;
  assign load_fire = load && !cmd_end;
  assign adv_fire  = advance && active && !load && !cmd_end;

  addr_seq_mode_reg u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (load_fire),
    .mode_code(mode),
    .mode_q   (mode_q)
  );

  addr_seq_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .mode_q(mode_q),
    .cur   (addr),
    .nxt   (step_addr)
  );

  addr_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_fire(load_fire),
    .adv_fire (adv_fire),
    .end_fire (end_fire),
    .mode_q   (mode_q),
    .active   (active),
    .more_ok  (more_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         addr <= '0;
    else if (load_fire) addr <= load_addr;
    else if (adv_fire)  addr <= step_addr;
  end
endmodule

// File: rtl/addr_seq_chk.sv
module addr_seq_chk
  import addr_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_end,
  input logic              load,
  input logic              advance,
  input logic [ADDR_W-1:0] load_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              more_ok,
  input logic              active,
  input logic              adv_fire,
  input seq_mode_e         mode_q
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cmd_end) |=> (addr == $past(load_addr) && more_ok)); // R2
  AST_PAGE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == SEQ_PAGE) |=>
      (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]) &&
       addr[PAGE_W-1:0] == $past(addr[PAGE_W-1:0]) + PAGE_W'(1))); // R3
  AST_PAGE_MORE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == SEQ_PAGE) |=> more_ok); // R4
  AST_BURST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == SEQ_BURST) |=> (addr == $past(addr) + ADDR_W'(1))); // R5
  AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_fire && mode_q == SEQ_SINGLE) |=> ($stable(addr) && !more_ok)); // R6
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !active && !load) |=> ($stable(addr) && $stable(more_ok))); // R9
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_end |=> (!more_ok && !active && $stable(addr))); // R10
endmodule

bind addr_seq addr_seq_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_end  (cmd_end),
  .load     (load),
  .advance  (advance),
  .load_addr(load_addr),
  .addr     (addr),
  .more_ok  (more_ok),
  .active   (active),
  .adv_fire (adv_fire),
  .mode_q   (mode_q)
);

// File: tb/addr_seq_tb.sv
module addr_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_end = 1'b0;
  logic        load = 1'b0;
  logic [14:0] load_addr = '0;
  logic [1:0]  mode = 2'b00;
  logic        advance = 1'b0;
  logic [14:0] addr;
  logic        more_ok;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  addr_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_end(cmd_end), .load(load),
    .load_addr(load_addr), .mode(mode), .advance(advance),
    .addr(addr), .more_ok(more_ok)
  );

  function automatic logic [14:0] ref_page(input logic [14:0] a);
    logic [4:0] lo;
    lo = 5'((int'(a[4:0]) + 1) % 32);
    return {a[14:5], lo};
  endfunction

  function automatic logic [14:0] ref_burst(input logic [14:0] a);
    return 15'((int'(a) + 1) % 32768);
  endfunction

  task automatic tick();
    @(posedge clk); #5;
    load = 1'b0; advance = 1'b0; cmd_end = 1'b0;
  endtask

  task automatic chk(input string req, input logic [14:0] ea, input logic em);
    checks++;
    if (addr !== ea || more_ok !== em) begin
      fails++;
      $display("FAIL %s: addr=%h more_ok=%b expected addr=%h more_ok=%b",
               req, addr, more_ok, ea, em);
    end
  endtask

  task automatic do_load(input logic [14:0] a, input logic [1:0] m);
    load = 1'b1; load_addr = a; mode = m; tick();
  endtask

  task automatic do_adv();
    advance = 1'b1; tick();
  endtask

  task automatic do_end();
    cmd_end = 1'b1; tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
    chk("R1", 15'h0000, 1'b0);
  endtask

  task automatic t_idle();
    do_adv(); chk("R9 after reset", 15'h0000, 1'b0);
    do_load(15'h0444, 2'b01); do_end();
    do_adv(); chk("R9 after end", 15'h0444, 1'b0);
  endtask

  task automatic t_page();
    logic [14:0] e;
    do_load(15'h1234, 2'b10); chk("R2", 15'h1234, 1'b1);
    e = 15'h1234;
    for (int i = 0; i < 14; i++) begin
      do_adv(); e = ref_page(e); chk("R3", e, 1'b1);
    end
    chk("R3 wrapped", 15'h1222, 1'b1);
    do_end();
  endtask

  task automatic t_page_loop();
    logic [14:0] e;
    do_load(15'h7FDE, 2'b10);
    e = 15'h7FDE;
    for (int i = 0; i < 70; i++) begin
      do_adv(); e = ref_page(e);
    end
    chk("R4", e, 1'b1);
    chk("R4 final", 15'h7FC4, 1'b1);
    do_end();
  endtask

  task automatic t_burst();
    logic [14:0] e;
    do_load(15'h7FFD, 2'b01);
    e = 15'h7FFD;
    for (int i = 0; i < 4; i++) begin
      do_adv(); e = ref_burst(e); chk("R5", e, 1'b1);
    end
    chk("R5 wrapped", 15'h0001, 1'b1);
    do_end();
  endtask

  task automatic t_single(input logic [1:0] m, input string req);
    do_load(15'h0100, m); chk(req, 15'h0100, 1'b1);
    do_adv(); chk(req, 15'h0100, 1'b0);
    do_adv(); chk(req, 15'h0100, 1'b0);
    do_end();
  endtask

  task automatic t_latch();
    do_load(15'h001F, 2'b10);
    mode = 2'b01;
    do_adv(); chk("R8 page kept", 15'h0000, 1'b1);
    do_end();
    do_load(15'h0200, 2'b00);
    mode = 2'b01;
    do_adv(); chk("R8 single kept", 15'h0200, 1'b0);
    do_end();
  endtask

  task automatic t_end_prio();
    do_load(15'h0050, 2'b01); do_adv();
    do_end(); chk("R10", 15'h0051, 1'b0);
    cmd_end = 1'b1; load = 1'b1; load_addr = 15'h0123; mode = 2'b01; tick();
    chk("R10 beats load", 15'h0051, 1'b0);
  endtask

  task automatic t_load_prio();
    do_load(15'h0300, 2'b01);
    load = 1'b1; advance = 1'b1; load_addr = 15'h0400; mode = 2'b01; tick();
    chk("R11", 15'h0400, 1'b1);
    do_adv(); chk("R11 then step", 15'h0401, 1'b1);
    do_end();
  endtask

  initial begin
    #5;
    t_reset();
    t_idle();
    t_page();
    t_page_loop();
    t_burst();
    t_single(2'b00, "R6");
    t_single(2'b11, "R7");
    t_latch();
    t_end_prio();
    t_load_prio();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule